// File: doc/BRIEF.md
# Dual-Mode Processor Register Bridge

This block lets an 8-bit local processor read and write a bank of 128 byte-wide registers. One set of bus pins serves two bus styles, and a static mode input picks the style. In the first style an active-high address-latch pulse captures the address. Separate active-low read and write strobes then perform the access, and an active-low ready output ends the processor's wait states. In the second style an active-low address strobe captures the address. An active-low data strobe qualifies the access, a direction line selects read or write, and an active-low acknowledge output completes the transfer.

The bus pins are asynchronous to the block. Every control pin passes through a two-flop synchronizer into the system clock, and edges are detected there. The data bus is split into an input, an output and an output enable, and the pad ring builds the tri-state driver from them. The address and write data must be stable around the strobe edges that sample them.

Top module: `cpu_reg_bridge`

## Requirements
- R1: After reset every register reads back as 0x00, `ack_n` is high and `dout_oe` is low.
- R2: With `mode_sel`=0 (latch-enable style), the address is captured on the falling edge of the active-high `alat`. A rising edge of `alat` captures nothing.
- R3: With `mode_sel`=1 (strobe style), `alat` is an active-low address strobe, and the address is captured on its rising edge.
- R4: With `mode_sel`=0, while `stb_a` (read strobe, active low) is low, `dout_oe` is high and `dout` carries the addressed register. `dout_oe` is low again 3 clocks after `stb_a` returns high.
- R5: With `mode_sel`=0, `din` is stored into the addressed register when `stb_b` (write strobe, active low) rises.
- R6: With `mode_sel`=1, `stb_a` is the active-low data strobe and `stb_b` is the direction line (1 = read, 0 = write). A falling data strobe with direction 0 stores `din`. With direction 1 the strobe drives the register onto `dout` with `dout_oe` high.
- R7: In both modes `ack_n` goes low exactly 4 clocks after the active strobe falls: 2 synchronizer clocks plus ACK_DLY=2 clocks after detection.
- R8: `ack_n` returns high 3 clocks after the strobe returns inactive or after `cs_n` goes high.
- R9: While `cs_n` is high, strobes cause no register write, no `dout_oe` and no `ack_n`.
- R10: `dout_oe` stays low throughout a write cycle in either mode.
- R11: A read returns the last value written to the same address, whichever mode performed the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| mode_sel | input | 1 | 0 = latch-enable style, 1 = strobe style (static) |
| cs_n | input | 1 | Active-low chip select |
| addr | input | 7 | Register address |
| alat | input | 1 | Address latch enable (mode 0) or address strobe, active low (mode 1) |
| stb_a | input | 1 | Read strobe (mode 0) or data strobe (mode 1), active low |
| stb_b | input | 1 | Write strobe, active low (mode 0) or read/write direction (mode 1) |
| din | input | 8 | Write data from the bus |
| dout | output | 8 | Read data to the bus |
| dout_oe | output | 1 | Bus output enable |
| ack_n | output | 1 | Ready (mode 0) or transfer acknowledge (mode 1), active low |

## Verification
A vector table interleaves reads and writes in both modes. It writes in one style and reads back in the other, and it overwrites an address. Together these separate a correct shared register bank from one that keeps separate storage per mode or that loses the latest write. For the address latch, the bench changes the address between the two edges of the latch pulse. The value read back then shows which edge the design used in each mode. Directed cases drive strobes with chip select high and drop chip select in the middle of a read. These show that a deselected block neither writes nor drives the bus, and that the acknowledge is released by either cause.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

  typedef enum logic {
    BUS_LATCH = 1'b0,
    BUS_STROBE = 1'b1
  } bus_style_e;

  function automatic logic went_low(input logic prev, input logic cur);
    return prev & ~cur;
  endfunction

  function automatic logic went_high(input logic prev, input logic cur);
    return ~prev & cur;
  endfunction

endpackage

// File: rtl/bridge_sync.sv
module bridge_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q   <= RST_VAL;
      sync_out <= RST_VAL;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/bridge_decode.sv
module bridge_decode
  import bridge_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  bus_style_e style,
  input  logic       cs_s,
  input  logic       lat_s,
  input  logic       sa_s,
  input  logic       sb_s,
  output logic       addr_latch,
  output logic       evt_start,
  output logic       wr_commit,
  output logic       rd_active,
  output logic       release_req,
  output logic       cs_idle
);
  logic lat_p, sa_p, sb_p;
  logic strobe_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_p <= 1'b0;
      sa_p  <= 1'b1;
      sb_p  <= 1'b1;
    end else begin
      lat_p <= lat_s;
      sa_p  <= sa_s;
      sb_p  <= sb_s;
    end
  end

  assign cs_idle = cs_s;

  always_comb begin
    if (style == BUS_LATCH) begin
      addr_latch = went_low(lat_p, lat_s);
      evt_start  = ~cs_s & (went_low(sa_p, sa_s) | went_low(sb_p, sb_s));
      wr_commit  = ~cs_s & went_high(sb_p, sb_s);
      rd_active  = ~cs_s & ~sa_s & sb_s & sb_p;
      strobe_act = ~sa_s | ~sb_s;
    end else begin
      addr_latch = went_high(lat_p, lat_s);
      evt_start  = ~cs_s & went_low(sa_p, sa_s);
      wr_commit  = ~cs_s & went_low(sa_p, sa_s) & ~sb_s;
      rd_active  = ~cs_s & ~sa_s & sb_s;
      strobe_act = ~sa_s;
    end
    release_req = cs_s | ~strobe_act;
  end
endmodule

// File: rtl/bridge_regfile.sv
module bridge_regfile #(
  parameter int AW = 7,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/bridge_ack.sv
module bridge_ack #(
  parameter int DLY = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt_start,
  input  logic release_req,
  output logic ack_n
);
  logic [DLY-1:0] stg;
  logic           ack_lo;

  assign stg[0] = evt_start & ~release_req;

  generate
    for (genvar i = 1; i < DLY; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           stg[i] <= 1'b0;
        else if (release_req) stg[i] <= 1'b0;
        else                  stg[i] <= stg[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           ack_lo <= 1'b0;
    else if (release_req) ack_lo <= 1'b0;
    else if (stg[DLY-1])  ack_lo <= 1'b1;
  end

  assign ack_n = ~ack_lo;
endmodule

// File: rtl/cpu_reg_bridge.sv
module cpu_reg_bridge
  import bridge_pkg::*;
#(
  parameter int AW      = 7,
  parameter int DW      = 8,
  parameter int ACK_DLY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_sel,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  logic          alat,
  input  logic          stb_a,
  input  logic          stb_b,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          ack_n
);
  localparam int NSYNC = 4;
  localparam logic [NSYNC-1:0] SYNC_RST = 4'b1011;

  bus_style_e     style;
  logic [NSYNC-1:0] raw_in, sync_v;
  logic           cs_s, lat_s, sa_s, sb_s;
  logic           addr_latch, evt_start, wr_commit, rd_active;
  logic           release_req, cs_idle;
  logic [AW-1:0]  addr_q;
  logic [DW-1:0]  rdata;

  assign style  = bus_style_e'(mode_sel);
  assign raw_in = {cs_n, lat_q_in(alat), stb_a, stb_b};

  function automatic logic lat_q_in(input logic v);
    return v;
  endfunction

  bridge_sync #(.W(NSYNC), .RST_VAL(SYNC_RST)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_in), .sync_out(sync_v)
  );

  assign {cs_s, lat_s, sa_s, sb_s} = sync_v;

  bridge_decode u_dec (
    .clk(clk), .rst_n(rst_n), .style(style),
    .cs_s(cs_s), .lat_s(lat_s), .sa_s(sa_s), .sb_s(sb_s),
    .addr_latch(addr_latch), .evt_start(evt_start), .wr_commit(wr_commit),
    .rd_active(rd_active), .release_req(release_req), .cs_idle(cs_idle)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          addr_q <= '0;
    else if (addr_latch) addr_q <= addr;
  end

  bridge_regfile #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(wr_commit), .waddr(addr_q),
    .wdata(din), .raddr(addr_q), .rdata(rdata)
  );

  bridge_ack #(.DLY(ACK_DLY)) u_ack (
    .clk(clk), .rst_n(rst_n), .evt_start(evt_start),
    .release_req(release_req), .ack_n(ack_n)
  );

  assign dout_oe = rd_active;
  assign dout    = rd_active ? rdata : '0;
endmodule

// File: rtl/cpu_reg_bridge_chk.sv
module cpu_reg_bridge_chk #(
  parameter int AW      = 7,
  parameter int ACK_DLY = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ack_n,
  input logic          dout_oe,
  input logic          evt_start,
  input logic          release_req,
  input logic          cs_idle,
  input logic          wr_commit,
  input logic          addr_latch,
  input logic [AW-1:0] addr_q
);
  localparam int CW = $clog2(ACK_DLY + 2) + 1;

  logic [CW-1:0] since_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    since_evt <= '0;
    else if (release_req)          since_evt <= '0;
    else if (evt_start)            since_evt <= CW'(1);
    else if (since_evt != '0 && since_evt <= CW'(ACK_DLY))
                                   since_evt <= since_evt + CW'(1);
  end

  AST_ACK_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
    (since_evt == CW'(ACK_DLY)) |-> !ack_n); // R7
  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    release_req |=> ack_n); // R8
  AST_CS_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cs_idle |-> !dout_oe); // R9
  AST_NO_OE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> !dout_oe); // R10
  AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_latch |=> $stable(addr_q)); // R2
endmodule

bind cpu_reg_bridge cpu_reg_bridge_chk #(.AW(AW), .ACK_DLY(ACK_DLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .ack_n(ack_n), .dout_oe(dout_oe),
  .evt_start(evt_start), .release_req(release_req), .cs_idle(cs_idle),
  .wr_commit(wr_commit), .addr_latch(addr_latch), .addr_q(addr_q)
);

// File: tb/cpu_reg_bridge_tb.sv
module cpu_reg_bridge_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_sel = 1'b0;
  logic       cs_n = 1'b1;
  logic [6:0] addr = '0;
  logic       alat = 1'b0;
  logic       stb_a = 1'b1;
  logic       stb_b = 1'b1;
  logic [7:0] din = '0;
  logic [7:0] dout;
  logic       dout_oe;
  logic       ack_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model [128];

  always #2.5 clk = ~clk;

  cpu_reg_bridge u_dut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .cs_n(cs_n), .addr(addr),
    .alat(alat), .stb_a(stb_a), .stb_b(stb_b), .din(din), .dout(dout),
    .dout_oe(dout_oe), .ack_n(ack_n)
  );

  // {mode, write, addr[6:0], data[7:0]}
  localparam int NV = 11;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0, 1'b1, 7'h05, 8'hA5},
    {1'b1, 1'b0, 7'h05, 8'h00},
    {1'b1, 1'b1, 7'h7F, 8'h3C},
    {1'b0, 1'b0, 7'h7F, 8'h00},
    {1'b0, 1'b1, 7'h00, 8'hFF},
    {1'b0, 1'b1, 7'h00, 8'h11},
    {1'b1, 1'b0, 7'h00, 8'h00},
    {1'b1, 1'b1, 7'h40, 8'hC3},
    {1'b1, 1'b0, 7'h40, 8'h00},
    {1'b0, 1'b0, 7'h40, 8'h00},
    {1'b0, 1'b0, 7'h12, 8'h00}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_mode(input logic m);
    mode_sel = m;
    alat     = m;
    stb_a    = 1'b1;
    stb_b    = 1'b1;
    step(4);
  endtask

  task automatic latch_addr(input logic [6:0] a);
    addr = a;
    alat = ~mode_sel;
    step(3);
    alat = mode_sel;
    step(3);
  endtask

  // one access at the latched address; checks ack timing, oe and data
  task automatic access(input logic wr, input logic [6:0] a, input logic [7:0] d);
    if (mode_sel == 1'b0) begin
      if (wr) begin din = d; stb_b = 1'b0; end
      else stb_a = 1'b0;
    end else begin
      stb_b = ~wr;
      din   = d;
      stb_a = 1'b0;
    end
    step(3);
    chk(ack_n === 1'b1, "R7 ack not early", ack_n, 1);
    step(1);
    chk(ack_n === 1'b0, "R7 ack after 4 clocks", ack_n, 0);
    if (wr) begin
      chk(dout_oe === 1'b0, "R10 oe low in write", dout_oe, 0);
    end else begin
      chk(dout_oe === 1'b1, mode_sel ? "R6 oe in read" : "R4 oe in read", dout_oe, 1);
      chk(dout === model[a], "R11 read data", dout, model[a]);
    end
    if (mode_sel == 1'b0) begin
      stb_a = 1'b1;
      stb_b = 1'b1;
    end else begin
      stb_a = 1'b1;
    end
    step(3);
    chk(ack_n === 1'b1, "R8 ack released", ack_n, 1);
    chk(dout_oe === 1'b0, "R4 oe released", dout_oe, 0);
    if (mode_sel) stb_b = 1'b1;
    if (wr) model[a] = d;
    step(1);
  endtask

  initial begin
    for (int i = 0; i < 128; i++) model[i] = 8'h00;
    step(3);
    rst_n = 1'b1;
    step(2);
    chk(ack_n === 1'b1, "R1 ack idle after reset", ack_n, 1);
    chk(dout_oe === 1'b0, "R1 oe idle after reset", dout_oe, 0);
    cs_n = 1'b0;
    set_mode(1'b0);
    latch_addr(7'h00);
    access(1'b0, 7'h00, 8'h00);   // R1 reset contents
    latch_addr(7'h7F);
    access(1'b0, 7'h7F, 8'h00);   // R1

    // vector table: R5 R6 R11
    for (int v = 0; v < NV; v++) begin
      if (mode_sel != VEC[v][16]) set_mode(VEC[v][16]);
      latch_addr(VEC[v][14:8]);
      access(VEC[v][15], VEC[v][14:8], VEC[v][7:0]);
    end

    // R2: address changes between the two edges of the latch pulse
    set_mode(1'b0);
    addr = 7'h05; alat = 1'b1; step(3);
    addr = 7'h7F; step(2);
    alat = 1'b0; step(3);
    addr = 7'h12;
    access(1'b0, 7'h7F, 8'h00);   // R2 falling edge captured 7F

    // R3: strobe style captures on rising edge of the address strobe
    set_mode(1'b1);
    addr = 7'h05; alat = 1'b0; step(3);
    addr = 7'h40; step(2);
    alat = 1'b1; step(3);
    addr = 7'h00;
    access(1'b0, 7'h40, 8'h00);   // R3 rising edge captured 40

    // R9: strobes ignored while deselected
    set_mode(1'b0);
    latch_addr(7'h05);
    cs_n = 1'b1; step(3);
    din = 8'h99; stb_b = 1'b0; step(5);
    chk(ack_n === 1'b1, "R9 no ack when deselected", ack_n, 1);
    stb_b = 1'b1; step(3);
    stb_a = 1'b0; step(5);
    chk(dout_oe === 1'b0, "R9 no oe when deselected", dout_oe, 0);
    chk(ack_n === 1'b1, "R9 no ack on read when deselected", ack_n, 1);
    stb_a = 1'b1; step(3);
    set_mode(1'b1);
    stb_b = 1'b0; din = 8'h77; stb_a = 1'b0; step(5);
    chk(ack_n === 1'b1, "R9 no ack strobe style deselected", ack_n, 1);
    stb_a = 1'b1; stb_b = 1'b1; step(3);
    cs_n = 1'b0; step(3);
    set_mode(1'b0);
    latch_addr(7'h05);
    access(1'b0, 7'h05, 8'h00);   // R9 value unchanged

    // R8: chip select dropped in the middle of a read
    stb_a = 1'b0; step(4);
    chk(ack_n === 1'b0, "R7 ack before deselect", ack_n, 0);
    cs_n = 1'b1; step(3);
    chk(ack_n === 1'b1, "R8 ack released by cs", ack_n, 1);
    chk(dout_oe === 1'b0, "R8 oe released by cs", dout_oe, 0);
    stb_a = 1'b1; cs_n = 1'b0; step(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule